// File: doc/BRIEF.md
# Skewed-Pipeline Dependency Issue Interlock

This block sits at the issue stage of an in-order, single-issue core. The core has two execution pipes. An address pipe computes addresses for loads and stores and returns load data. An ALU pipe handles register arithmetic. The ALU pipe reads its operands and writes its results one cycle later than the address pipe. Because of that offset, the minimum gap between a producer and a dependent instruction depends on both ends of the dependency. It depends on whether the producer is a load or an ALU operation, and on whether the consumer reads its operands in the address pipe or in the ALU pipe.

Each cycle the issue logic presents one candidate to the block: its class, two source register numbers and one destination register number. The block answers in the same cycle. `issue_ok` means the candidate issues in this cycle. `stall` means the candidate must be held and shown again in the next cycle.

Each register has a countdown that is set when a producer of that register issues. A candidate that is held is checked again every cycle. It goes out in the first cycle in which both of its sources are far enough from their producers. Register 0 is never a dependency.

Top module: `skew_issue_lock`

## Requirements
- R1: Synchronous reset clears every dependency. After reset, any valid candidate issues at once.
- R2: An instruction that uses the address pipe may issue no earlier than 4 cycles after a load that writes one of its sources. This covers a load or a store, with either source. If the load issues in cycle t, the consumer stalls in cycles t+1 to t+3 and issues in cycle t+4.
- R3: An ALU instruction that reads a load result may issue 3 cycles after the load. It stalls in cycles t+1 and t+2 and issues in cycle t+3.
- R4: An ALU instruction that reads the result of the ALU instruction issued one cycle earlier issues at once, with no stall.
- R5: An instruction that uses the address pipe and reads an ALU result must wait 2 cycles. It stalls in cycle t+1 and issues in cycle t+2.
- R6: Register 0 is never a dependency. A load that names register 0 as its destination creates no stall. A source of register 0 never causes a stall.
- R7: When `cand_valid` is high, exactly one of `issue_ok` and `stall` is high. When `cand_valid` is low, both outputs are low.
- R8: A candidate that does not issue writes nothing to the scoreboard. This covers a candidate with `cand_valid` low and a candidate that is stalled. A store never writes its destination field.
- R9: A newer producer of a register replaces the older one's countdown. For example, a load to register r followed one cycle later by an ALU write of r lets an ALU reader of r issue in the very next cycle.
- R10: Both sources are checked. A dependency on the second source alone is enough to stall.
- R11: The candidate class is a 2-bit code: 0 is an ALU instruction, 1 is a load, 2 is a store, and 3 is reserved. A reserved code reads its sources in the address pipe and writes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_valid | input | 1 | A candidate is presented this cycle |
| cand_class | input | 2 | Candidate class: 0 ALU, 1 load, 2 store, 3 reserved |
| cand_src_a | input | 5 | First source register; the address base for a load or store |
| cand_src_b | input | 5 | Second source register; the store data for a store |
| cand_dst | input | 5 | Destination register; used only by ALU instructions and loads |
| issue_ok | output | 1 | The candidate issues this cycle |
| stall | output | 1 | The candidate is held this cycle |

## Verification
The checker assumes that the issue logic keeps presenting a stalled candidate unchanged until it issues. It also assumes that at most one instruction issues per cycle. The timing properties look at only one cycle of history. They cover the one-cycle cases, R4 and R5 at cycle t+1, and they leave the longer load distances to the bench. The stimulus table follows these rules. It holds each stalled candidate steady until it issues, and it separates independent scenarios by registers that are not yet in use.

// File: rtl/skew_issue_pkg.sv
package skew_issue_pkg;

  typedef enum logic [1:0] {
    CLS_ALU   = 2'd0,
    CLS_LOAD  = 2'd1,
    CLS_STORE = 2'd2,
    CLS_RSVD  = 2'd3
  } cand_class_e;

  // True when the class reads its operands in the address pipe.
  function automatic logic is_addr_consumer(input logic [1:0] cls);
    return cls != CLS_ALU;
  endfunction

  // True when the class produces a register result.
  function automatic logic is_producer(input logic [1:0] cls);
    return (cls == CLS_ALU) || (cls == CLS_LOAD);
  endfunction

endpackage

// File: rtl/skew_scoreboard.sv
module skew_scoreboard #(
  parameter int NREG  = 32,
  parameter int IDX_W = 5,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [CNT_W-1:0] wr_val,
  input  logic [IDX_W-1:0] rd_a,
  input  logic [IDX_W-1:0] rd_b,
  output logic [CNT_W-1:0] cnt_a,
  output logic [CNT_W-1:0] cnt_b
);

  logic [CNT_W-1:0] cnt_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      // Register 0 is hard-wired: it never carries a dependency.
      assign cnt_q[g] = '0;
    end else begin : g_track
      logic [CNT_W-1:0] c;
      always_ff @(posedge clk) begin
        if (rst) begin
          c <= '0;
        end else if (wr_en && (wr_idx == IDX_W'(g))) begin
          c <= wr_val;
        end else if (c != '0) begin
          c <= c - 1'b1;
        end
      end
      assign cnt_q[g] = c;
    end
  end

  assign cnt_a = cnt_q[rd_a];
  assign cnt_b = cnt_q[rd_b];

endmodule

// File: rtl/skew_hazard_check.sv
module skew_hazard_check
  import skew_issue_pkg::*;
#(
  parameter int CNT_W = 3,
  parameter int SKEW  = 1
) (
  input  logic [1:0]       cls,
  input  logic [CNT_W-1:0] cnt_a,
  input  logic [CNT_W-1:0] cnt_b,
  output logic             hazard
);

  // A counter holds the cycles left before an address-pipe reader may issue.
  // An ALU reader uses its operands SKEW cycles later, so it may issue
  // while up to SKEW cycles still remain.
  localparam logic [CNT_W-1:0] ALU_SLACK = CNT_W'(SKEW);

  logic addr_side;
  logic haz_a, haz_b;

  always_comb begin
    addr_side = is_addr_consumer(cls);
    if (addr_side) begin
      haz_a = cnt_a != '0;
      haz_b = cnt_b != '0;
    end else begin
      haz_a = cnt_a > ALU_SLACK;
      haz_b = cnt_b > ALU_SLACK;
    end
    hazard = haz_a || haz_b;
  end

endmodule

// File: rtl/skew_issue_lock.sv
module skew_issue_lock
  import skew_issue_pkg::*;
#(
  parameter int NREG     = 32,
  parameter int LOAD_LAT = 4,
  parameter int ALU_LAT  = 1,
  parameter int SKEW     = 1,
  parameter int IDX_W    = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cand_valid,
  input  logic [1:0]       cand_class,
  input  logic [IDX_W-1:0] cand_src_a,
  input  logic [IDX_W-1:0] cand_src_b,
  input  logic [IDX_W-1:0] cand_dst,
  output logic             issue_ok,
  output logic             stall
);

  // Issue distances, measured for an address-pipe reader.
  localparam int LOAD_DIST = LOAD_LAT;
  localparam int ALU_DIST  = ALU_LAT + SKEW;
  localparam int MAX_DIST  = (LOAD_DIST > ALU_DIST) ? LOAD_DIST : ALU_DIST;
  localparam int CNT_W     = $clog2(MAX_DIST + 1);
  localparam logic [CNT_W-1:0] LOAD_SET = CNT_W'(LOAD_DIST - 1);
  localparam logic [CNT_W-1:0] ALU_SET  = CNT_W'(ALU_DIST - 1);

  logic [CNT_W-1:0] cnt_a, cnt_b;
  logic             hazard;
  logic             fire;
  logic             wr_en;
  logic [CNT_W-1:0] wr_val;

  skew_scoreboard #(
    .NREG (NREG),
    .IDX_W(IDX_W),
    .CNT_W(CNT_W)
  ) i_sb (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .wr_idx(cand_dst),
    .wr_val(wr_val),
    .rd_a  (cand_src_a),
    .rd_b  (cand_src_b),
    .cnt_a (cnt_a),
    .cnt_b (cnt_b)
  );

  skew_hazard_check #(
    .CNT_W(CNT_W),
    .SKEW (SKEW)
  ) i_hz (
    .cls   (cand_class),
    .cnt_a (cnt_a),
    .cnt_b (cnt_b),
    .hazard(hazard)
  );

  always_comb begin
    fire   = cand_valid && !hazard;
    wr_en  = fire && is_producer(cand_class) && (cand_dst != '0);
    wr_val = (cand_class == CLS_LOAD) ? LOAD_SET : ALU_SET;
  end

  assign issue_ok = fire;
  assign stall    = cand_valid && hazard;

endmodule

// File: rtl/skew_issue_lock_chk.sv
module skew_issue_lock_chk #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             cand_valid,
  input logic [1:0]       cand_class,
  input logic [IDX_W-1:0] cand_src_a,
  input logic [IDX_W-1:0] cand_src_b,
  input logic [IDX_W-1:0] cand_dst,
  input logic             issue_ok,
  input logic             stall
);

  // R7
  one_of_two_chk: assert property (@(posedge clk) disable iff (rst)
    cand_valid |-> (issue_ok != stall));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !cand_valid |-> (!issue_ok && !stall));

  // R6
  zero_src_free_chk: assert property (@(posedge clk) disable iff (rst)
    (cand_valid && cand_src_a == '0 && cand_src_b == '0) |-> issue_ok);

  // R4
  alu_back2back_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(issue_ok) && $past(cand_class) == 2'd0 &&
     $past(cand_dst) != '0 && cand_valid && cand_class == 2'd0 &&
     cand_src_a == $past(cand_dst) && cand_src_b == '0) |-> issue_ok);

  // R5
  alu_to_addr_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(issue_ok) && $past(cand_class) == 2'd0 &&
     $past(cand_dst) != '0 && cand_valid && cand_class != 2'd0 &&
     cand_src_a == $past(cand_dst)) |-> stall);

  // R2
  load_to_addr_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(issue_ok) && $past(cand_class) == 2'd1 &&
     $past(cand_dst) != '0 && cand_valid && cand_class != 2'd0 &&
     cand_src_b == $past(cand_dst)) |-> stall);

endmodule

bind skew_issue_lock skew_issue_lock_chk #(.IDX_W(IDX_W)) i_chk (.*);

// File: tb/test_skew_issue_lock.sv
module test_skew_issue_lock;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 20;

  logic       clk = 1'b0;
  logic       rst;
  logic       cand_valid;
  logic [1:0] cand_class;
  logic [4:0] cand_src_a, cand_src_b, cand_dst;
  logic       issue_ok, stall;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  skew_issue_lock i_skew_issue_lock (
    .clk(clk), .rst(rst), .cand_valid(cand_valid), .cand_class(cand_class),
    .cand_src_a(cand_src_a), .cand_src_b(cand_src_b), .cand_dst(cand_dst),
    .issue_ok(issue_ok), .stall(stall)
  );

  // Each row is one cycle: {valid, class, src_a, src_b, dst, exp_ok, exp_stall}.
  // Classes: 0 ALU, 1 load, 2 store.
  localparam logic [19:0] VEC [NVEC] = '{
    {1'b1, 2'd1, 5'd0,  5'd0, 5'd5,  1'b1, 1'b0}, // 0  load r5 (R1)
    {1'b1, 2'd2, 5'd5,  5'd0, 5'd0,  1'b0, 1'b1}, // 1  store base r5, t+1 (R2)
    {1'b1, 2'd2, 5'd5,  5'd0, 5'd0,  1'b0, 1'b1}, // 2  t+2 (R2)
    {1'b1, 2'd2, 5'd5,  5'd0, 5'd0,  1'b0, 1'b1}, // 3  t+3 (R2)
    {1'b1, 2'd2, 5'd5,  5'd0, 5'd0,  1'b1, 1'b0}, // 4  t+4 issues (R2)
    {1'b1, 2'd1, 5'd0,  5'd0, 5'd6,  1'b1, 1'b0}, // 5  load r6
    {1'b1, 2'd0, 5'd6,  5'd0, 5'd7,  1'b0, 1'b1}, // 6  ALU reads r6, t+1 (R3)
    {1'b1, 2'd0, 5'd6,  5'd0, 5'd7,  1'b0, 1'b1}, // 7  t+2 (R3)
    {1'b1, 2'd0, 5'd6,  5'd0, 5'd7,  1'b1, 1'b0}, // 8  t+3 issues, writes r7 (R3)
    {1'b1, 2'd0, 5'd7,  5'd0, 5'd8,  1'b1, 1'b0}, // 9  ALU after ALU (R4)
    {1'b1, 2'd1, 5'd8,  5'd0, 5'd9,  1'b0, 1'b1}, // 10 load base r8, t+1 (R5)
    {1'b1, 2'd1, 5'd8,  5'd0, 5'd9,  1'b1, 1'b0}, // 11 t+2 issues (R5)
    {1'b1, 2'd1, 5'd0,  5'd0, 5'd0,  1'b1, 1'b0}, // 12 load to r0 (R6)
    {1'b1, 2'd2, 5'd0,  5'd0, 5'd0,  1'b1, 1'b0}, // 13 store reads r0 (R6)
    {1'b1, 2'd2, 5'd0,  5'd9, 5'd0,  1'b0, 1'b1}, // 14 store data r9 only (R10)
    {1'b0, 2'd1, 5'd0,  5'd0, 5'd10, 1'b0, 1'b0}, // 15 invalid load r10 (R7 R8)
    {1'b1, 2'd0, 5'd10, 5'd0, 5'd11, 1'b1, 1'b0}, // 16 reader of r10 free (R8)
    {1'b1, 2'd1, 5'd0,  5'd0, 5'd12, 1'b1, 1'b0}, // 17 load r12
    {1'b1, 2'd0, 5'd0,  5'd0, 5'd12, 1'b1, 1'b0}, // 18 ALU rewrites r12 (R9)
    {1'b1, 2'd0, 5'd12, 5'd0, 5'd13, 1'b1, 1'b0}  // 19 ALU reads r12 (R9)
  };

  task automatic drive(input logic v, input logic [1:0] c,
                       input logic [4:0] a, input logic [4:0] b, input logic [4:0] d);
    cand_valid = v; cand_class = c; cand_src_a = a; cand_src_b = b; cand_dst = d;
  endtask

  task automatic check(input string req, input logic exp_ok, input logic exp_st);
    total++;
    if (issue_ok !== exp_ok || stall !== exp_st) begin
      bad++;
      $display("FAIL %s: issue_ok=%b stall=%b expected issue_ok=%b stall=%b",
               req, issue_ok, stall, exp_ok, exp_st);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] c, input logic [4:0] a,
                      input logic [4:0] b, input logic [4:0] d,
                      input string req, input logic eo, input logic es);
    @(negedge clk);
    drive(v, c, a, b, d);
    #1;
    check(req, eo, es);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    drive(1'b0, 2'd0, 5'd0, 5'd0, 5'd0);
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset idle", 1'b0, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      logic [19:0] v;
      v = VEC[i];
      step(v[19], v[18:17], v[16:12], v[11:7], v[6:2],
           $sformatf("R1-table row %0d", i), v[1], v[0]);
    end

    // R8: a stalled load must not record its destination.
    step(1'b1, 2'd1, 5'd0, 5'd0, 5'd14, "R8 load r14", 1'b1, 1'b0);
    step(1'b1, 2'd1, 5'd14, 5'd0, 5'd15, "R8 stalled load r15", 1'b0, 1'b1);
    step(1'b1, 2'd0, 5'd15, 5'd0, 5'd16, "R8 reader of r15 free", 1'b1, 1'b0);

    // R11: reserved class reads in the address pipe and writes nothing.
    step(1'b1, 2'd0, 5'd0, 5'd0, 5'd17, "R11 ALU writes r17", 1'b1, 1'b0);
    step(1'b1, 2'd3, 5'd17, 5'd0, 5'd18, "R11 reserved reads r17", 1'b0, 1'b1);
    step(1'b1, 2'd3, 5'd17, 5'd0, 5'd18, "R11 reserved issues", 1'b1, 1'b0);
    step(1'b1, 2'd0, 5'd18, 5'd0, 5'd0, "R11 reserved wrote nothing", 1'b1, 1'b0);

    // R8: a store's destination field is not recorded.
    step(1'b1, 2'd2, 5'd0, 5'd0, 5'd19, "R8 store dst r19", 1'b1, 1'b0);
    step(1'b1, 2'd2, 5'd19, 5'd0, 5'd0, "R8 store dst unused", 1'b1, 1'b0);

    // R1: reset in the middle of a dependency clears it.
    step(1'b1, 2'd1, 5'd0, 5'd0, 5'd20, "R1 load r20", 1'b1, 1'b0);
    @(negedge clk);
    drive(1'b0, 2'd0, 5'd0, 5'd0, 5'd0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    step(1'b1, 2'd2, 5'd20, 5'd0, 5'd0, "R1 after reset r20 free", 1'b1, 1'b0);

    step(1'b0, 2'd0, 5'd0, 5'd0, 5'd0, "R7 idle end", 1'b0, 1'b0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule